// File: doc/BRIEF.md
# Edge-Clearable Input Capture Timer

An 8-bit up-counter that advances on enable pulses from a selectable prescaler. Three rates come from a free-running divider of the system clock; the fourth divides an externally supplied slow tick strobe by four. The counter can be forced to zero by a programmable edge of an external capture input, which first passes through a two-flop synchronizer. The same synchronized input drives a single-cycle capture interrupt on a selectable edge.

One 8-bit mode/control register is reached through a simple read/write strobe port. Its bit layout, from bit 7 down to bit 0, is: `flag_hi`, `flag_lo`, `ovf_ie`, `cap_edge_sel`, `clr_mode[1:0]`, `rate_sel[1:0]`. When the counter wraps from 0xFF to 0x00, one of the two sticky overflow flags is set. `flag_hi` is set if the synchronized capture input was high at the wrap, and `flag_lo` if it was low. Software clears a flag with a two-step handshake. Each flag is tracked by a small state machine with three states:
- `FLG_IDLE`: the flag reads 0.
- `FLG_PENDING`: the flag reads 1 and has not yet been read.
- `FLG_ARMED`: the flag reads 1 and has been read.

The state machine has these transitions:
- *set*: `FLG_IDLE` to `FLG_PENDING`.
- *read*: `FLG_PENDING` to `FLG_ARMED`.
- *clear*: `FLG_ARMED` to `FLG_IDLE`, on a write of 0 with no set event in the same cycle.
- *disarm*: `FLG_ARMED` to `FLG_PENDING`, on any other write.

Top module: `edge_clr_timer`

## Requirements
- R1: After reset the control register reads 0x00, the counter is 0x00 and both interrupt requests are low.
- R2: `rate_sel` (bits 1:0) sets the count rate. 00 gives one count per 64 clocks, 01 one per 32 clocks, 10 one per 2 clocks, and 11 one per four `wclk_tick` strobes. Without an enable the counter holds its value.
- R3: `clr_mode` (bits 3:2) selects which synchronized capture edges clear the counter. 00 clears on no edge, 01 on falling edges, 10 on rising edges and 11 on both.
- R4: A clear takes priority over a count enable in the same cycle and loads 0x00. A clear never sets an overflow flag.
- R5: A wrap from 0xFF to 0x00 sets bit 7 if the synchronized capture input is high, and sets bit 6 if it is low.
- R6: A flag clears only when a 0 is written to it after it was read as 1. Writing 1, or writing 0 without a prior read, leaves it set. A set event in the same cycle as a clearing write keeps the flag set.
- R7: `ovf_irq` is high exactly when `ovf_ie` (bit 5) is 1 and at least one overflow flag is set.
- R8: `cap_irq` is a one-cycle pulse on a synchronized rising edge when `cap_edge_sel` (bit 4) is 0, and on a falling edge when it is 1.
- R9: A write stores bits 5:0 of the write data, and these read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wclk_tick | input | 1 | Slow tick strobe, one clock wide |
| cap_in | input | 1 | Asynchronous capture input |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (arms set flags) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| count_o | output | 8 | Current counter value |
| ovf_irq | output | 1 | Overflow interrupt request (level) |
| cap_irq | output | 1 | Capture edge interrupt request (pulse) |

## Verification
The bench builds the block with its default parameters: a 6-bit divider, a 2-bit tick divider, two synchronizer stages and an 8-bit counter. With these values a wrap takes about 512 clocks at the fastest internal rate. Overflow flags are therefore reached within a few hundred cycles, and both flags can be set just by holding the capture level. Exact-window count deltas confirm each rate code. All eight pairings of clear mode and edge direction are exercised against the capture interrupt select.

// File: rtl/timer_pkg.sv
package timer_pkg;

    typedef enum logic [1:0] {
        RATE_DIV64  = 2'b00,
        RATE_DIV32  = 2'b01,
        RATE_DIV2   = 2'b10,
        RATE_WATCH4 = 2'b11
    } rate_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE = 2'b00,
        CLR_FALL = 2'b01,
        CLR_RISE = 2'b10,
        CLR_BOTH = 2'b11
    } clr_mode_e;

    typedef enum logic [1:0] {
        FLG_IDLE    = 2'b00,
        FLG_PENDING = 2'b01,
        FLG_ARMED   = 2'b10
    } flag_state_e;

    localparam int BIT_FLAG_HI = 7;
    localparam int BIT_FLAG_LO = 6;
    localparam int BIT_OVF_IE  = 5;
    localparam int BIT_EDGE    = 4;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import timer_pkg::*;
#(
    parameter int DIV_W  = 6,
    parameter int WDIV_W = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wclk_tick,
    input  rate_sel_e rate,
    output logic      cnt_en
);
    logic [DIV_W-1:0]  div_q;
    logic [WDIV_W-1:0] wdiv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q  <= '0;
            wdiv_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
            if (wclk_tick) begin
                wdiv_q <= wdiv_q + 1'b1;
            end
        end
    end

    always_comb begin
        unique case (rate)
            RATE_DIV64:  cnt_en = &div_q;
            RATE_DIV32:  cnt_en = &div_q[DIV_W-2:0];
            RATE_DIV2:   cnt_en = div_q[0];
            RATE_WATCH4: cnt_en = wclk_tick & (&wdiv_q);
            default:     cnt_en = 1'b0;
        endcase
    end

    // After a slow-divider enable the divider restarts, so no internal rate fires next
    assert_div_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && rate == RATE_DIV64) |=> (!cnt_en || rate == RATE_WATCH4));

endmodule

// File: rtl/tmr_cap_edge.sv
module tmr_cap_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cap_in,
    output logic level,
    output logic rise,
    output logic fall
);
    localparam int SR_W = SYNC_STAGES + 1;

    logic [SR_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= {sr_q[SR_W-2:0], cap_in};
        end
    end

    assign level = sr_q[SYNC_STAGES-1];
    assign rise  = sr_q[SYNC_STAGES-1] & ~sr_q[SYNC_STAGES];
    assign fall  = ~sr_q[SYNC_STAGES-1] & sr_q[SYNC_STAGES];

    assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rise || fall) |=> !(rise || fall));
    assert_edge_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rise, fall}));

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign count = cnt_q;
    assign wrap  = en & ~clr & (&cnt_q);

    assert_clear_loads_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0));
    assert_hold_without_enable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(count));
    assert_clear_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> !wrap);

endmodule

// File: rtl/tmr_ovf_flag.sv
module tmr_ovf_flag
    import timer_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_ev,
    input  logic rd_ev,
    input  logic wr_ev,
    input  logic wr_bit,
    output logic flag
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FLG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: begin
                if (set_ev) state_d = FLG_PENDING;
            end
            FLG_PENDING: begin
                if (wr_ev)      state_d = FLG_PENDING;
                else if (rd_ev) state_d = FLG_ARMED;
            end
            FLG_ARMED: begin
                if (wr_ev) begin
                    if (!wr_bit && !set_ev) state_d = FLG_IDLE;
                    else                    state_d = FLG_PENDING;
                end
            end
            default: state_d = FLG_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FLG_IDLE:    flag = 1'b0;
            FLG_PENDING: flag = 1'b1;
            FLG_ARMED:   flag = 1'b1;
            default:     flag = 1'b0;
        endcase
    end

    assert_set_reaches_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_ev |=> flag);
    assert_sticky_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !wr_ev) |=> flag);
    assert_no_spurious_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_ev) |=> !flag);
    assert_write_one_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && wr_ev && wr_bit) |=> flag);

endmodule

// File: rtl/edge_clr_timer.sv
module edge_clr_timer
    import timer_pkg::*;
#(
    parameter int DIV_W       = 6,
    parameter int WDIV_W      = 2,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wclk_tick,
    input  logic             cap_in,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    output logic [CNT_W-1:0] count_o,
    output logic             ovf_irq,
    output logic             cap_irq
);
    logic [5:0] ctrl_q;
    logic       flag_hi, flag_lo;
    logic       cnt_en, clr_pulse, wrap;
    logic       cap_lvl, cap_rise, cap_fall;
    rate_sel_e  rate;
    clr_mode_e  clr_mode;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (reg_wr) begin
            ctrl_q <= reg_wdata[5:0];
        end
    end

    assign rate     = rate_sel_e'(ctrl_q[1:0]);
    assign clr_mode = clr_mode_e'(ctrl_q[3:2]);

    tmr_prescaler #(.DIV_W(DIV_W), .WDIV_W(WDIV_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .wclk_tick(wclk_tick),
        .rate(rate), .cnt_en(cnt_en)
    );

    tmr_cap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in),
        .level(cap_lvl), .rise(cap_rise), .fall(cap_fall)
    );

    always_comb begin
        unique case (clr_mode)
            CLR_NONE: clr_pulse = 1'b0;
            CLR_FALL: clr_pulse = cap_fall;
            CLR_RISE: clr_pulse = cap_rise;
            CLR_BOTH: clr_pulse = cap_rise | cap_fall;
            default:  clr_pulse = 1'b0;
        endcase
    end

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(clr_pulse),
        .count(count_o), .wrap(wrap)
    );

    tmr_ovf_flag u_flag_hi (
        .clk(clk), .rst_n(rst_n), .set_ev(wrap & cap_lvl),
        .rd_ev(reg_rd), .wr_ev(reg_wr), .wr_bit(reg_wdata[BIT_FLAG_HI]),
        .flag(flag_hi)
    );

    tmr_ovf_flag u_flag_lo (
        .clk(clk), .rst_n(rst_n), .set_ev(wrap & ~cap_lvl),
        .rd_ev(reg_rd), .wr_ev(reg_wr), .wr_bit(reg_wdata[BIT_FLAG_LO]),
        .flag(flag_lo)
    );

    assign reg_rdata = {flag_hi, flag_lo, ctrl_q};
    assign ovf_irq   = ctrl_q[BIT_OVF_IE] & (flag_hi | flag_lo);
    assign cap_irq   = ctrl_q[BIT_EDGE] ? cap_fall : cap_rise;

    assert_ctrl_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_rdata[5:0] == $past(reg_wdata[5:0])));
    assert_cap_irq_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_irq |=> !cap_irq);
    assert_irq_needs_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_irq |-> (reg_rdata[7] || reg_rdata[6]));

endmodule

// File: tb/edge_clr_timer_tb_top.sv
`timescale 1ns/1ps
module edge_clr_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wclk_tick = 1'b0;
    logic       cap_in = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic [7:0] count_o;
    logic       ovf_irq, cap_irq;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    edge_clr_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wclk_tick(wclk_tick), .cap_in(cap_in),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .count_o(count_o),
        .ovf_irq(ovf_irq), .cap_irq(cap_irq)
    );

    // rate code, window length in clocks, expected count delta
    localparam logic [1:0] RATE_CODE [0:3] = '{2'b00, 2'b01, 2'b10, 2'b11};
    localparam int         RATE_WIN  [0:3] = '{64, 64, 64, 80};
    localparam int         RATE_DLT  [0:3] = '{1, 2, 32, 2};

    // {clr_mode[1:0], rising, edge_sel, expect_clear, expect_irq}
    localparam logic [5:0] CLR_VEC [0:7] = '{
        6'b00_1_0_0_1, 6'b00_0_1_0_1,
        6'b01_1_1_0_0, 6'b01_0_0_1_0,
        6'b10_1_1_1_0, 6'b10_0_0_0_0,
        6'b11_1_0_1_1, 6'b11_0_1_1_1
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(output logic [7:0] v);
        @(negedge clk);
        reg_rd = 1'b1;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // slow tick strobe, one clock high every 10 clocks
    initial begin
        forever begin
            repeat (9) @(negedge clk);
            wclk_tick = 1'b1;
            @(negedge clk);
            wclk_tick = 1'b0;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv, c0, c1, d;
        int pulses;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 8'h00, "R1 ctrl reset", reg_rdata, 0);
        chk(count_o == 8'h00, "R1 counter reset", count_o, 0);
        chk(ovf_irq == 1'b0, "R1 ovf_irq reset", ovf_irq, 0);
        chk(cap_irq == 1'b0, "R1 cap_irq reset", cap_irq, 0);

        // R9 readback of bits 5:0
        reg_write(8'hFF);
        reg_read(rv);
        chk(rv == 8'h3F, "R9 readback", rv, 8'h3F);
        reg_write(8'h00);

        // R2 rate table
        for (int i = 0; i < 4; i++) begin
            reg_write({6'b0, RATE_CODE[i]});
            idle(4);
            c0 = count_o;
            idle(RATE_WIN[i]);
            c1 = count_o;
            d = c1 - c0;
            chk(d == 8'(RATE_DLT[i]), $sformatf("R2 rate code %0d delta", i), d, RATE_DLT[i]);
        end

        // R3/R4/R8 clear-mode and capture-interrupt table
        for (int i = 0; i < 8; i++) begin
            logic start_lvl;
            start_lvl = ~CLR_VEC[i][3];
            reg_write(8'b0000_1110);       // both-edge clear, rate 10
            cap_in = ~start_lvl;
            idle(6);
            cap_in = start_lvl;
            idle(6);
            reg_write({2'b00, 1'b0, CLR_VEC[i][2], CLR_VEC[i][5:4], 2'b10});
            idle(40);
            c0 = count_o;
            pulses = 0;
            @(negedge clk);
            cap_in = ~start_lvl;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (cap_irq) pulses++;
            end
            c1 = count_o;
            if (CLR_VEC[i][1]) begin
                chk(c1 <= 8'd3, $sformatf("R3 R4 entry %0d cleared to zero", i), c1, 0);
            end else begin
                chk(c1 > c0, $sformatf("R3 entry %0d not cleared", i), c1, c0 + 3);
            end
            chk(pulses == int'(CLR_VEC[i][0]), $sformatf("R8 entry %0d cap_irq pulses", i),
                pulses, CLR_VEC[i][0]);
        end
        reg_read(rv);
        chk(rv[7:6] == 2'b00, "R4 clears set no flag", rv[7:6], 0);

        // R5 wrap with capture low sets bit 6
        reg_write(8'h02);
        cap_in = 1'b0;
        idle(600);
        reg_read(rv);
        chk(rv == 8'h42, "R5 low-level wrap sets bit 6", rv, 8'h42);
        reg_write(8'h00);                  // write 0 after read: clears (armed)
        reg_read(rv);
        chk(rv == 8'h00, "R6 read then write 0 clears", rv, 8'h00);

        // second overflow, now with write-0-without-read
        reg_write(8'h02);
        idle(520);
        reg_write(8'h00);                  // not read since set: must not clear
        reg_read(rv);
        chk(rv == 8'h40, "R6 write 0 without read keeps flag", rv, 8'h40);
        chk(ovf_irq == 1'b0, "R7 irq off when ovf_ie 0", ovf_irq, 0);
        reg_write(8'hE0);                  // write 1 after read: no effect, enable irq
        @(negedge clk);
        chk(ovf_irq == 1'b1, "R7 irq on with flag and ovf_ie", ovf_irq, 1);
        reg_read(rv);
        chk(rv == 8'h60, "R6 write 1 keeps flag", rv, 8'h60);
        reg_write(8'h20);
        @(negedge clk);
        chk(ovf_irq == 1'b0, "R7 irq drops after clear", ovf_irq, 0);
        reg_read(rv);
        chk(rv == 8'h20, "R6 flag cleared by protocol", rv, 8'h20);

        // R5 wrap with capture high sets bit 7
        cap_in = 1'b1;
        reg_write(8'h22);
        idle(600);
        reg_read(rv);
        chk(rv == 8'hA2, "R5 high-level wrap sets bit 7", rv, 8'hA2);
        chk(ovf_irq == 1'b1, "R7 irq from bit 7", ovf_irq, 1);
        reg_write(8'h00);
        reg_read(rv);
        chk(rv == 8'h00, "R6 bit 7 cleared", rv, 8'h00);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule